// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken. The only input to the guess is the branch's own address. It keeps a table of 2-bit saturating counters. The fetch stage presents a PC on the lookup port and gets a taken or not-taken guess back in the same cycle, together with the raw counter value. When the branch later resolves, the back end presents its PC and the real outcome on the update port. The selected counter then moves one step toward that outcome.

The table index is a plain bit slice of the PC that skips the two alignment bits, so no arithmetic is needed. Every entry starts from the weakly-taken state. After reset a sweep writes that value into the table one entry per cycle. While the sweep runs, a busy flag is high, every lookup answers taken, and updates are dropped. Each entry costs two bits, so the default 4096-entry table holds 8192 bits of state.

Top module: `bimodal_predictor`

## Requirements
- R1: Counter codes are 2'b00 strongly not-taken, 2'b01 weakly not-taken, 2'b10 weakly taken, 2'b11 strongly taken. `pred_ctr` is the 2-bit code of the entry the lookup PC selects, and `pred_taken` equals bit 1 of that code.
- R2: The entry is chosen by PC bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). PC bits [1:0] and all bits above IDX_W+1 do not affect which entry is chosen.
- R3: An accepted update with `upd_taken`=1 raises the counter by one step, and one with `upd_taken`=0 lowers it by one step. The direction does not depend on what the counter currently predicts.
- R4: Counters saturate. Taken at 2'b11 leaves 2'b11, and not-taken at 2'b00 leaves 2'b00.
- R5: After the reset sweep has finished, every entry reads 2'b10, and `pred_taken` is 1 for any PC that has not been updated.
- R6: `init_busy` stays high for exactly ENTRIES cycles after reset is released. While it is high, `pred_taken`=1 and `pred_ctr`=2'b10, and any update is discarded.
- R7: When `upd_valid`=0, no entry changes, whatever is on `upd_pc` and `upd_taken`.
- R8: When a lookup and an accepted update select the same entry in the same cycle, the lookup returns the value from before the update. The new value is visible from the next cycle.
- R9: From a saturated state, one contrary outcome leaves the prediction unchanged, and a second consecutive contrary outcome flips it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the init sweep |
| lookup_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | Guess: 1 = taken |
| pred_ctr | output | 2 | Counter value of the looked-up entry |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome: 1 = taken |
| init_busy | output | 1 | High while the reset sweep is writing the table |

## Verification
The bench counts the cycles `init_busy` stays high and fires an update during the sweep. An off-by-one sweep or an ungated update port shows up as a wrong cycle count or a counter that is no longer 2'b10 afterwards. It drives counters into both rails and pushes past them: a wrapping design would read 2'b00 after a taken update at 2'b11.

It walks a strongly taken entry down one step at a time to show the hysteresis. It also updates an entry that predicts not-taken with a taken outcome, which exposes a design that steps on correctness instead of on the outcome. Finally, it aliases PCs that differ only in the low two bits or above the index, and it collides a lookup with an update in the same cycle. Together these catch a shifted index slice and a write-first read.

// File: rtl/bimodal_pkg.sv
package bimodal_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_SNT = 2'b00;
    localparam ctr_t CTR_WNT = 2'b01;
    localparam ctr_t CTR_WT  = 2'b10;
    localparam ctr_t CTR_ST  = 2'b11;

    // One saturating step toward the resolved direction.
    function automatic ctr_t sat_step(input ctr_t cur, input logic up);
        ctr_t nxt;
        if (up) nxt = (cur == CTR_ST)  ? CTR_ST  : cur + 2'd1;
        else    nxt = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // Alignment bits and high bits are not used for indexing.
    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:IDX_W+2], pc[1:0]};

    assign idx = pc[IDX_W+1:2];
endmodule

// File: rtl/bp_init_seq.sv
module bp_init_seq #(
    parameter int ENTRIES = 4096,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             busy,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] ptr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            s_d.ptr = s_q.ptr + 1'b1;
            if (s_q.ptr == LAST) s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{busy: 1'b1, ptr: '0};
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign ptr  = s_q.ptr;

    AST_SWEEP_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> $past(s_q.ptr) == LAST); // R6
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
    import bimodal_pkg::*;
#(
    parameter int ENTRIES = 4096,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_val,
    input  logic             init_en,
    input  logic [IDX_W-1:0] init_idx,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] widx;
        ctr_t             wval;
    } wr_t;

    ctr_t mem_q [ENTRIES];
    wr_t  wr_d;

    // Read-before-write: combinational read of the registered array.
    assign rd_val = mem_q[rd_idx];

    always_comb begin
        wr_d = '{we: 1'b0, widx: upd_idx, wval: sat_step(mem_q[upd_idx], upd_taken)};
        if (init_en) begin
            wr_d.we   = 1'b1;
            wr_d.widx = init_idx;
            wr_d.wval = CTR_WT;
        end else if (upd_en) begin
            wr_d.we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_d.we) mem_q[wr_d.widx] <= wr_d.wval;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !init_en && upd_taken && mem_q[upd_idx] == CTR_ST
        |=> mem_q[$past(upd_idx)] == CTR_ST); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !init_en && !upd_taken && mem_q[upd_idx] == CTR_SNT
        |=> mem_q[$past(upd_idx)] == CTR_SNT); // R4
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !init_en && upd_taken && mem_q[upd_idx] != CTR_ST
        |=> mem_q[$past(upd_idx)] == $past(mem_q[upd_idx]) + 2'd1); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !init_en && !upd_taken && mem_q[upd_idx] != CTR_SNT
        |=> mem_q[$past(upd_idx)] == $past(mem_q[upd_idx]) - 2'd1); // R3
endmodule

// File: rtl/bimodal_predictor.sv
module bimodal_predictor
    import bimodal_pkg::*;
#(
    parameter int ENTRIES = 4096,
    parameter int PC_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lookup_pc,
    output logic            pred_taken,
    output logic [1:0]      pred_ctr,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    output logic            init_busy
);
    logic [IDX_W-1:0] lk_idx, up_idx, sweep_ptr;
    logic             sweeping;
    logic             tbl_upd_en;
    ctr_t             rd_val;

    bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx (.pc(lookup_pc), .idx(lk_idx));
    bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_idx (.pc(upd_pc),    .idx(up_idx));

    bp_init_seq #(.ENTRIES(ENTRIES)) u_seq (
        .clk(clk), .rst_n(rst_n), .busy(sweeping), .ptr(sweep_ptr)
    );

    assign tbl_upd_en = upd_valid && !sweeping;

    bp_counter_table #(.ENTRIES(ENTRIES)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_val(rd_val),
        .init_en(sweeping), .init_idx(sweep_ptr),
        .upd_en(tbl_upd_en), .upd_idx(up_idx), .upd_taken(upd_taken)
    );

    always_comb begin
        pred_ctr   = sweeping ? CTR_WT : rd_val;
        pred_taken = pred_ctr[1];
    end

    assign init_busy = sweeping;

    AST_BUSY_GUESS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> pred_taken && pred_ctr == CTR_WT); // R6
    AST_UPDATE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> !tbl_upd_en); // R6
endmodule

// File: tb/bimodal_predictor_test.sv
module bimodal_predictor_test;
    localparam int ENTRIES = 4096;
    localparam int PC_W    = 32;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lookup_pc = '0;
    logic            pred_taken;
    logic [1:0]      pred_ctr;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic            init_busy;

    int checks = 0;
    int fails  = 0;

    bimodal_predictor #(.ENTRIES(ENTRIES), .PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc),
        .pred_taken(pred_taken), .pred_ctr(pred_ctr),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .init_busy(init_busy)
    );

    always #10 clk = ~clk; // 50 MHz

    typedef struct {
        logic [1:0] exp_ctr;
        string      req;
    } item_t;

    item_t      sb_q[$];
    logic [1:0] model [ENTRIES];

    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    function automatic logic [1:0] step(input logic [1:0] c, input logic up);
        if (up) return (c == 2'b11) ? 2'b11 : c + 2'd1;
        return (c == 2'b00) ? 2'b00 : c - 2'd1;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare queued expectations against the outputs.
    always begin
        @(negedge clk);
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check({30'd0, pred_ctr}, {30'd0, it.exp_ctr}, it.req);
            check({31'd0, pred_taken}, {31'd0, it.exp_ctr[1]}, {it.req, " (taken bit)"});
        end
    end

    // Driver: one cycle with optional lookup expectation and optional update.
    task automatic cycle(input logic [PC_W-1:0] lpc, input logic do_look,
                         input logic [1:0] exp, input string req,
                         input logic uv, input logic [PC_W-1:0] upc, input logic ut);
        @(negedge clk);
        lookup_pc = lpc;
        upd_valid = uv;
        upd_pc    = upc;
        upd_taken = ut;
        if (do_look) sb_q.push_back('{exp, req});
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input string req);
        cycle(pc, 1'b1, model[idx_of(pc)], req, 1'b0, '0, 1'b0);
    endtask

    task automatic upd(input logic [PC_W-1:0] pc, input logic t);
        cycle('0, 1'b0, 2'b00, "", 1'b1, pc, t);
        model[idx_of(pc)] = step(model[idx_of(pc)], t);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int busy_cycles;
        for (int i = 0; i < ENTRIES; i++) model[i] = 2'b10;

        repeat (3) @(negedge clk);
        #2;
        check({31'd0, init_busy}, 32'd1, "R6 busy in reset");
        check({31'd0, pred_taken}, 32'd1, "R6 taken in reset");

        // Release reset and fire a not-taken update during the sweep.
        @(negedge clk);
        rst_n     = 1'b1;
        upd_valid = 1'b1;
        upd_pc    = 32'h0000_0014;
        upd_taken = 1'b0;
        #2;
        busy_cycles = 0;
        while (init_busy && busy_cycles < ENTRIES + 10) begin
            check({30'd0, pred_ctr}, 32'd2, "R6 ctr during sweep");
            busy_cycles++;
            @(negedge clk);
            upd_valid = 1'b1;
            #2;
        end
        upd_valid = 1'b0;
        check(busy_cycles, ENTRIES, "R6 sweep length");

        // R6: update during sweep discarded; R5 reset value everywhere.
        look(32'h0000_0014, "R6 sweep update ignored");
        look(32'h0000_0000, "R5 entry 0");
        look(32'h0000_3FFC, "R5 last entry");
        look(32'h0000_1230, "R5 mid entry");

        // R3/R4: climb to strongly taken and saturate.
        upd(32'h0000_0100, 1'b1);
        look(32'h0000_0100, "R3 increment to 11");
        upd(32'h0000_0100, 1'b1);
        look(32'h0000_0100, "R4 saturate at 11");
        check(model[idx_of(32'h100)], 2'b11, "R4 model sanity");

        // R9: two contrary outcomes from saturation.
        upd(32'h0000_0100, 1'b0);
        cycle(32'h0000_0100, 1'b1, 2'b10, "R9 first contrary keeps taken", 1'b0, '0, 1'b0);
        upd(32'h0000_0100, 1'b0);
        cycle(32'h0000_0100, 1'b1, 2'b01, "R9 second contrary flips", 1'b0, '0, 1'b0);

        // R4: floor at 00.
        upd(32'h0000_0100, 1'b0);
        upd(32'h0000_0100, 1'b0);
        cycle(32'h0000_0100, 1'b1, 2'b00, "R4 saturate at 00", 1'b0, '0, 1'b0);

        // R3: taken while predicting not-taken still increments.
        upd(32'h0000_0100, 1'b1);
        cycle(32'h0000_0100, 1'b1, 2'b01, "R3 step on outcome", 1'b0, '0, 1'b0);

        // R7: update lines without valid change nothing.
        cycle('0, 1'b0, 2'b00, "", 1'b0, 32'h0000_0200, 1'b0);
        cycle('0, 1'b0, 2'b00, "", 1'b0, 32'h0000_0200, 1'b1);
        cycle(32'h0000_0200, 1'b1, 2'b10, "R7 no valid no change", 1'b0, '0, 1'b0);

        // R2: aliasing through low bits and bits above the index.
        upd(32'h0000_0303, 1'b0);
        look(32'h0000_0300, "R2 low bits ignored");
        cycle(32'h0000_0300 + (ENTRIES << 2), 1'b1, 2'b01, "R2 high bits ignored", 1'b0, '0, 1'b0);
        look(32'h0000_0304, "R2 neighbour untouched");

        // R8: same-cycle lookup and update return the old value.
        cycle(32'h0000_0400, 1'b1, 2'b10, "R8 read before write",
              1'b1, 32'h0000_0400, 1'b1);
        model[idx_of(32'h400)] = 2'b11;
        cycle(32'h0000_0400, 1'b1, 2'b11, "R8 new value next cycle", 1'b0, '0, 1'b0);

        // R1: prediction bit follows the MSB of the counter.
        upd(32'h0000_0500, 1'b0);
        look(32'h0000_0500, "R1 weakly not-taken predicts 0");

        @(negedge clk);
        @(negedge clk);
        #4;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule